// File: doc/BRIEF.md
# Push-Button Master Volume Controller

This block keeps the digital master attenuation setting of a stereo output and the mute flag that goes with it. Two active-low push-button pins, one for "louder" and one for "softer", act on it, and so do host register writes. A pin press only counts once it has been held for a qualification time. From then on it moves the attenuation by one step when qualification completes and by one more step after each further stepping interval. Pressing both pins together mutes the output. Once the output is muted, the next qualified activity on either pin clears the mute.

The attenuation code is 5 bits wide. Code 0 means no attenuation, and each code step adds 1.5 dB, so code 31 means 46.5 dB of attenuation. A millisecond tick comes from the system clock through a prescaler parameter. Both the qualification time and the stepping interval are given in those ticks. The code and the mute flag drive the analog attenuator, which lies outside this block. The same two values also form a register that the host reads and writes.

Top module: `hwvol_ctrl`

## Requirements
- R1: After reset the attenuation code is 0 and mute is 0.
- R2: The pins are active low and pass through a two-flop synchronizer. A press released before it has been held for QUAL_MS ticks changes neither the code nor the mute flag.
- R3: When a press has been held for QUAL_MS ticks, it applies its first step in the cycle after the tick that completes qualification.
- R4: While the press stays held after qualification, a further step follows every STEP_MS ticks.
- R5: A step from the louder pin lowers the code by 1. A step from the softer pin raises the code by 1. The code changes by at most 1 per cycle unless the host writes it.
- R6: Stepping saturates: the code never goes below 0 or above 31, and it never wraps.
- R7: When both presses are qualified while the output is not muted, mute is set, the code is kept, and both presses are consumed. Presses that qualify on the same tick apply no step.
- R8: While muted, the first step event of a press that has not been consumed clears mute without changing the code. Every press held at that moment is consumed until its pin is released.
- R9: A host write loads the code from wdata[4:0] and mute from wdata[5]. It takes priority over any pin event in the same cycle.
- R10: status_o is {mute, code}, with mute in bit 5 and the code in bits 4:0. att_o and mute_o carry the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vol_up_n | input | 1 | Louder push-button, active low |
| vol_dn_n | input | 1 | Softer push-button, active low |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 6 | Host write value: [5] mute, [4:0] code |
| att_o | output | 5 | Attenuation code to the analog attenuator |
| mute_o | output | 1 | Mute flag to the analog attenuator |
| status_o | output | 6 | Host-readable register {mute, code} |

## Verification
The bench builds the block with TICK_DIV=4, QUAL_MS=5 and STEP_MS=8. With these values qualification takes about twenty clock cycles and the stepping interval is 32 cycles. Saturation at both ends, repeated stepping, chords pressed together or one after the other, consumed presses across a repeat boundary, and host-write priority while a pin is held can therefore all be reached within a few thousand cycles. A behavioural model counts elapsed milliseconds with plain integers and is compared against all outputs on every clock. Directed checks confirm the expected code and mute values at chosen points.

// File: rtl/hwvol_pkg.sv
package hwvol_pkg;

    localparam int unsigned ATT_W    = 5;
    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned PIN_UP   = 0;
    localparam int unsigned PIN_DN   = 1;

    typedef logic [ATT_W-1:0] att_t;

    localparam att_t ATT_MIN = '0;
    localparam att_t ATT_MAX = '1;

    // per-pin event bundle produced by the qualifier
    typedef struct packed {
        logic press;   // synchronized pin level, asserted
        logic qual;    // held long enough (including the qualifying tick)
        logic step;    // one-cycle step event
    } pin_evt_t;

    // controller state, also the layout of the host register
    typedef struct packed {
        logic mute;
        att_t att;
    } vol_state_t;

    function automatic att_t att_louder(input att_t a);
        return (a == ATT_MIN) ? a : att_t'(a - 1'b1);
    endfunction

    function automatic att_t att_softer(input att_t a);
        return (a == ATT_MAX) ? a : att_t'(a + 1'b1);
    endfunction

endpackage

// File: rtl/hwvol_tick.sv
module hwvol_tick #(
    parameter int unsigned TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    assign tick_o = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o); // R4
        end
    endgenerate

endmodule

// File: rtl/hwvol_pin_qual.sv
module hwvol_pin_qual
    import hwvol_pkg::*;
#(
    parameter int unsigned QUAL_MS = 25,
    parameter int unsigned STEP_MS = 1000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     pin_n_i,
    output pin_evt_t evt_o
);
    localparam int unsigned QW = $clog2(QUAL_MS + 1);
    localparam int unsigned RW = (STEP_MS > 1) ? $clog2(STEP_MS) : 1;
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_MS - 1);
    localparam logic [QW-1:0] Q_DONE = QW'(QUAL_MS);
    localparam logic [RW-1:0] R_LAST = RW'(STEP_MS - 1);

    logic [1:0]    sync_q;
    logic          press;
    logic [QW-1:0] held_q;
    logic [RW-1:0] rep_q;
    logic          held_done;
    logic          reach_now;
    logic          repeat_now;

    // two-flop synchronizer, inverted to active-high
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[0], ~pin_n_i};
        end
    end

    assign press      = sync_q[1];
    assign held_done  = (held_q == Q_DONE);
    assign reach_now  = tick_i && (held_q == Q_LAST);
    assign repeat_now = tick_i && held_done && (rep_q == R_LAST);

    always_ff @(posedge clk) begin
        if (rst || !press) begin
            held_q <= '0;
            rep_q  <= '0;
        end else if (tick_i) begin
            if (!held_done) begin
                held_q <= held_q + 1'b1;
            end else if (rep_q == R_LAST) begin
                rep_q <= '0;
            end else begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end

    always_comb begin
        evt_o.press = press;
        evt_o.qual  = press && (held_done || reach_now);
        evt_o.step  = press && (reach_now || repeat_now);
    end

    generate
        if (QUAL_MS > 1) begin : g_early_chk
            AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (rst)
                $rose(press) |-> !evt_o.step); // R2
        end
    endgenerate

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        evt_o.step |-> tick_i); // R3

endmodule

// File: rtl/hwvol_core.sv
module hwvol_core
    import hwvol_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_evt_t   evt_up_i,
    input  pin_evt_t   evt_dn_i,
    input  logic       host_we_i,
    input  vol_state_t host_wdata_i,
    output vol_state_t state_o
);
    vol_state_t            cur_q, nxt;
    logic [NUM_PINS-1:0]   blk_q, blk_n;
    logic                  up_live, dn_live;

    assign up_live = evt_up_i.step && !blk_q[PIN_UP];
    assign dn_live = evt_dn_i.step && !blk_q[PIN_DN];

    always_comb begin
        nxt   = cur_q;
        blk_n = blk_q;
        if (!cur_q.mute && evt_up_i.qual && evt_dn_i.qual) begin
            // chord: mute and consume both presses
            nxt.mute = 1'b1;
            blk_n    = '1;
        end else if (cur_q.mute && (up_live || dn_live)) begin
            // activity while muted: restore, no step
            nxt.mute      = 1'b0;
            blk_n[PIN_UP] = blk_q[PIN_UP] | evt_up_i.press;
            blk_n[PIN_DN] = blk_q[PIN_DN] | evt_dn_i.press;
        end else if (!cur_q.mute) begin
            if (up_live) begin
                nxt.att = att_louder(cur_q.att);
            end else if (dn_live) begin
                nxt.att = att_softer(cur_q.att);
            end
        end
        if (!evt_up_i.press) blk_n[PIN_UP] = 1'b0;
        if (!evt_dn_i.press) blk_n[PIN_DN] = 1'b0;
        if (host_we_i) begin
            nxt = host_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            blk_q <= '0;
        end else begin
            cur_q <= nxt;
            blk_q <= blk_n;
        end
    end

    assign state_o = cur_q;

    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!host_we_i && cur_q.att == ATT_MAX) |=> (cur_q.att != ATT_MIN)); // R6
    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
        (!host_we_i && cur_q.att == ATT_MIN) |=> (cur_q.att != ATT_MAX)); // R6
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        !host_we_i |=> ((int'(cur_q.att) - int'($past(cur_q.att)) <= 1) &&
                        (int'($past(cur_q.att)) - int'(cur_q.att) <= 1))); // R5
    AST_MUTED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!host_we_i && cur_q.mute) |=> (cur_q.att == $past(cur_q.att))); // R8
    AST_CHORD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!host_we_i && !cur_q.mute && evt_up_i.qual && evt_dn_i.qual)
            |=> (cur_q.mute && $stable(cur_q.att))); // R7
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
        host_we_i |=> (cur_q == $past(host_wdata_i))); // R9

endmodule

// File: rtl/hwvol_ctrl.sv
module hwvol_ctrl
    import hwvol_pkg::*;
#(
    parameter int unsigned TICK_DIV = 125000,
    parameter int unsigned QUAL_MS  = 25,
    parameter int unsigned STEP_MS  = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vol_up_n,
    input  logic             vol_dn_n,
    input  logic             host_we,
    input  logic [ATT_W:0]   host_wdata,
    output logic [ATT_W-1:0] att_o,
    output logic             mute_o,
    output logic [ATT_W:0]   status_o
);
    logic                tick;
    logic [NUM_PINS-1:0] pins_n;
    pin_evt_t            evt [NUM_PINS];
    vol_state_t          state;

    assign pins_n[PIN_UP] = vol_up_n;
    assign pins_n[PIN_DN] = vol_dn_n;

    hwvol_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            hwvol_pin_qual #(
                .QUAL_MS (QUAL_MS),
                .STEP_MS (STEP_MS)
            ) u_qual (
                .clk     (clk),
                .rst     (rst),
                .tick_i  (tick),
                .pin_n_i (pins_n[gi]),
                .evt_o   (evt[gi])
            );
        end
    endgenerate

    hwvol_core u_core (
        .clk          (clk),
        .rst          (rst),
        .evt_up_i     (evt[PIN_UP]),
        .evt_dn_i     (evt[PIN_DN]),
        .host_we_i    (host_we),
        .host_wdata_i (vol_state_t'(host_wdata)),
        .state_o      (state)
    );

    assign att_o    = state.att;
    assign mute_o   = state.mute;
    assign status_o = state;

    AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (rst)
        status_o == {mute_o, att_o}); // R10

endmodule

// File: tb/hwvol_ctrl_tb.sv
module hwvol_ctrl_tb;
    localparam int DIV   = 4;
    localparam int QUAL  = 5;
    localparam int STEP  = 8;
    localparam int AMAX  = 31;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_n = 1'b1;
    logic       dn_n = 1'b1;
    logic       we = 1'b0;
    logic [5:0] wdata = '0;
    logic [4:0] att_o;
    logic       mute_o;
    logic [5:0] status_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hwvol_ctrl #(.TICK_DIV(DIV), .QUAL_MS(QUAL), .STEP_MS(STEP)) u_dut (
        .clk(clk), .rst(rst), .vol_up_n(up_n), .vol_dn_n(dn_n),
        .host_we(we), .host_wdata(wdata),
        .att_o(att_o), .mute_o(mute_o), .status_o(status_o)
    );

    // behavioural reference: elapsed-millisecond bookkeeping
    int m_div, m_att;
    bit m_mute;
    bit m_s1[2], m_s2[2], m_blk[2];
    int m_el[2];
    bit tk;
    bit pr[2], ql[2], st[2];
    int nx[2];

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_att = 0; m_mute = 0;
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_blk[i] = 0; m_el[i] = 0;
            end
        end else begin
            tk = (m_div == DIV - 1);
            for (int i = 0; i < 2; i++) begin
                pr[i] = m_s2[i];
                nx[i] = m_el[i] + (tk ? 1 : 0);
                ql[i] = pr[i] && (nx[i] >= QUAL);
                st[i] = pr[i] && tk &&
                        (nx[i] == QUAL || (nx[i] > QUAL && ((nx[i] - QUAL) % STEP) == 0));
            end
            if (!m_mute && ql[0] && ql[1]) begin
                m_mute = 1; m_blk[0] = 1; m_blk[1] = 1;
            end else if (m_mute && ((st[0] && !m_blk[0]) || (st[1] && !m_blk[1]))) begin
                m_mute = 0;
                for (int i = 0; i < 2; i++) if (pr[i]) m_blk[i] = 1;
            end else if (!m_mute) begin
                if (st[0] && !m_blk[0]) begin
                    if (m_att > 0) m_att = m_att - 1;
                end else if (st[1] && !m_blk[1]) begin
                    if (m_att < AMAX) m_att = m_att + 1;
                end
            end
            for (int i = 0; i < 2; i++) if (!pr[i]) m_blk[i] = 0;
            if (we) begin
                m_att = int'(wdata[4:0]);
                m_mute = wdata[5];
            end
            for (int i = 0; i < 2; i++) m_el[i] = pr[i] ? nx[i] : 0;
            m_s2 = m_s1;
            m_s1[0] = ~up_n;
            m_s1[1] = ~dn_n;
            m_div = tk ? 0 : m_div + 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(att_o) != m_att || mute_o != m_mute) begin
                failures++;
                $display("FAIL R4 model cycle %0d: att=%0d mute=%0d expected att=%0d mute=%0d",
                         cyc, att_o, mute_o, m_att, m_mute);
            end
            checks++;
            if (status_o != {mute_o, att_o}) begin
                failures++;
                $display("FAIL R10 status=%0h expected %0h", status_o, {mute_o, att_o});
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input bit mute, input int code);
        we = 1'b1;
        wdata = {mute, 5'(code)};
        cycles(1);
        we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        chk("R1 reset code", int'(att_o), 0);
        chk("R1 reset mute", int'(mute_o), 0);

        host_write(0, 28);
        chk("R9 write code", int'(status_o), 28);

        // short press ignored
        dn_n = 1'b0; cycles(12); dn_n = 1'b1; cycles(10);
        chk("R2 short press", int'(att_o), 28);

        // hold softer to the top
        dn_n = 1'b0; cycles(200); dn_n = 1'b1; cycles(5);
        chk("R6 saturate high", int'(att_o), AMAX);

        // first step at qualification, then repeat
        up_n = 1'b0; cycles(30);
        chk("R3 first step", int'(att_o), 30);
        cycles(30);
        chk("R4 repeat step", int'(att_o), 29);
        up_n = 1'b1; cycles(5);
        chk("R5 louder lowers code", int'(att_o), 29);

        host_write(0, 2);
        up_n = 1'b0; cycles(150); up_n = 1'b1; cycles(5);
        chk("R6 saturate low", int'(att_o), 0);

        // simultaneous chord mutes with no step
        host_write(0, 10);
        up_n = 1'b0; dn_n = 1'b0; cycles(80);
        chk("R7 chord mute", int'(mute_o), 1);
        chk("R7 chord code kept", int'(att_o), 10);
        up_n = 1'b1; dn_n = 1'b1; cycles(5);
        chk("R7 still muted", int'(mute_o), 1);

        // unmute press, no step, consumed across repeat
        dn_n = 1'b0; cycles(40);
        chk("R8 unmuted", int'(mute_o), 0);
        chk("R8 no step on unmute", int'(att_o), 10);
        cycles(40);
        chk("R8 press consumed", int'(att_o), 10);
        dn_n = 1'b1; cycles(5);
        dn_n = 1'b0; cycles(30); dn_n = 1'b1; cycles(5);
        chk("R5 softer raises code", int'(att_o), 11);

        // host write of mute bit and register layout
        host_write(1, 5);
        chk("R10 status layout", int'(status_o), 37);
        chk("R9 write mute", int'(mute_o), 1);

        // host priority over held pin
        dn_n = 1'b0; we = 1'b1; wdata = {1'b0, 5'd7};
        cycles(60);
        we = 1'b0; dn_n = 1'b1; cycles(5);
        chk("R9 host priority", int'(att_o), 7);

        // staggered chord
        up_n = 1'b0; cycles(25);
        dn_n = 1'b0; cycles(40);
        chk("R7 staggered mute", int'(mute_o), 1);
        chk("R7 staggered code", int'(att_o), 6);
        up_n = 1'b1; dn_n = 1'b1; cycles(5);

        finish_run();
    end

endmodule